// File: doc/BRIEF.md
# Programmable Periodic Interval Timer with Sample-Rate Select

This block is an interval timer for a telecom PCM interface controller. Its time base is a single-cycle frame tick that arrives every 125 µs. Every second frame tick forms a 250 µs base step. An 8-bit write-only configuration word sets the timer. Its low seven bits hold a period value `N`, and its top bit selects the signaling sample rate. After a start strobe, the timer fires once every `N + 1` base steps. This gives periods from 250 µs to 32 ms.

Each firing produces a one-cycle timer interrupt pulse. It also produces a frame-sync multiframe pulse when the multiframe mode input is high. A third output is a last-look sampling strobe. When the select bit is clear, this strobe follows the programmed period. When the select bit is set, it fires on every frame tick (125 µs), and the interrupt and multiframe outputs keep the programmed period.

Any write to the configuration word stops the timer. Deasserting the operating-mode input also stops it. A fresh start strobe is needed to run again, and the count then begins from a full period. Decoding of the host bus, interrupt status storage and signaling comparison are handled elsewhere.

Top module: `pcm_interval_timer`

## Requirements
- R1: After reset the configuration word is 0x00, `running` is 0 and all three pulse outputs are 0. A start with no write then gives a period of 2 frame ticks.
- R2: With period value N (bits 6..0 of the configuration word), `tmr_irq_pulse` fires on the 2·(N+1)-th frame tick after the start strobe, and then every 2·(N+1) frame ticks. This includes N = 0 and N = 127.
- R3: A start strobe sets `running` when there is no write in the same cycle and `op_mode_en` is 1. A start strobe while `op_mode_en` is 0 leaves the timer stopped.
- R4: Any configuration write clears `running`. A write and a start strobe in the same cycle leave the timer stopped.
- R5: Driving `op_mode_en` low clears `running`.
- R6: While stopped, no pulse appears on any output, whatever frame ticks arrive.
- R7: `mf_sync_pulse` fires together with `tmr_irq_pulse` when `mf_mode_sel` is 1. It stays 0 when `mf_mode_sel` is 0.
- R8: With bit 7 of the configuration word at 0, `lastlook_pulse` fires exactly when `tmr_irq_pulse` fires.
- R9: With bit 7 at 1, `lastlook_pulse` fires once for every frame tick while running. `tmr_irq_pulse` keeps the period from R2.
- R10: After a write stops the timer, the next start counts a full period of the newly written value.
- R11: Each pulse is one clock wide. It is high in the cycle after the clock edge that samples the completing frame tick, and low on all other cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_tick | input | 1 | One-cycle strobe every 125 µs |
| cfg_wr | input | 1 | Write strobe for the configuration word |
| cfg_wdata | input | 8 | Configuration data: bit 7 sample-rate select, bits 6..0 period value |
| start_cmd | input | 1 | Start command strobe |
| op_mode_en | input | 1 | Operating mode enable; low stops the timer |
| mf_mode_sel | input | 1 | Enables multiframe pulse generation |
| running | output | 1 | Timer is running |
| tmr_irq_pulse | output | 1 | Timer interrupt event pulse |
| mf_sync_pulse | output | 1 | Multiframe frame-sync pulse |
| lastlook_pulse | output | 1 | Last-look signaling sample strobe |

## Verification
A wrong count register or a wrong base-divider phase does not show up at once. It appears as an interrupt pulse on the wrong frame tick, which can be as late as 256 frame ticks after the start, so the tests measure the index of the first firing and not only the number of firings. A stale `running` flag shows up as pulses during stopped windows. Each stop scenario is therefore followed by a window of ticks in which every output must stay quiet. A wrong sample-rate selection changes the last-look count by a factor of 2·(N+1) within one period.

// File: rtl/pit_pkg.sv
package pit_pkg;
   typedef enum logic {
      LL_PROGRAMMED = 1'b0,
      LL_FRAME      = 1'b1
   } ll_src_e;
endpackage

// File: rtl/pit_ctrl.sv
module pit_ctrl #(
   parameter int TVAL_W = 7
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_wr,
   input  logic [TVAL_W:0]   cfg_wdata,
   input  logic              start_cmd,
   input  logic              op_mode_en,
   input  logic              frame_tick,
   output logic [TVAL_W-1:0] period_val,
   output pit_pkg::ll_src_e  ll_src,
   output logic              running,
   output logic              load,
   output logic              active,
   output logic              frame_ev
);
   logic [TVAL_W:0] cfg_q;
   logic            stop_now;

   assign stop_now   = cfg_wr | ~op_mode_en;
   assign load       = start_cmd & ~stop_now;
   assign active     = running & ~stop_now;
   assign frame_ev   = active & frame_tick;
   assign period_val = cfg_q[TVAL_W-1:0];
   assign ll_src     = pit_pkg::ll_src_e'(cfg_q[TVAL_W]);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg_q   <= '0;
         running <= 1'b0;
      end else begin
         if (cfg_wr) cfg_q <= cfg_wdata;
         if (stop_now)   running <= 1'b0;
         else if (load)  running <= 1'b1;
      end
   end

   p_write_stops_r4: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_wr |=> !running);
   p_mode_stops_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !op_mode_en |=> !running);
   p_start_runs_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (start_cmd && !cfg_wr && op_mode_en) |=> running);
endmodule

// File: rtl/pit_base_div.sv
module pit_base_div #(
   parameter int FRAME_DIV = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic restart,
   input  logic frame_ev,
   output logic base_tick
);
   initial assert (FRAME_DIV >= 1) else $fatal(1, "FRAME_DIV must be at least 1");

   generate
      if (FRAME_DIV == 1) begin : g_pass
         assign base_tick = frame_ev;
      end else begin : g_div
         localparam int DW = $clog2(FRAME_DIV);
         localparam logic [DW-1:0] LAST = DW'(FRAME_DIV - 1);
         logic [DW-1:0] phase_q;

         assign base_tick = frame_ev & (phase_q == LAST);

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)          phase_q <= '0;
            else if (restart)    phase_q <= '0;
            else if (base_tick)  phase_q <= '0;
            else if (frame_ev)   phase_q <= phase_q + 1'b1;
         end

         p_phase_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
            phase_q <= LAST);
      end
   endgenerate
endmodule

// File: rtl/pit_period_cnt.sv
module pit_period_cnt #(
   parameter int TVAL_W = 7
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [TVAL_W-1:0] reload_val,
   input  logic              base_tick,
   input  logic              running,
   output logic              expire
);
   initial assert (TVAL_W >= 1) else $fatal(1, "TVAL_W must be at least 1");

   logic [TVAL_W-1:0] cnt_q;

   assign expire = base_tick & (cnt_q == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          cnt_q <= '0;
      else if (load)       cnt_q <= reload_val;
      else if (base_tick)  cnt_q <= (cnt_q == '0) ? reload_val : cnt_q - 1'b1;
   end

   p_count_bound_r10: assert property (@(posedge clk) disable iff (!rst_n)
      running |-> (cnt_q <= reload_val));
   p_reload_after_fire_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (expire && !load) |=> (cnt_q == $past(reload_val)));
endmodule

// File: rtl/pit_strobe_out.sv
module pit_strobe_out (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             expire,
   input  logic             frame_ev,
   input  logic             active,
   input  logic             mf_mode_sel,
   input  pit_pkg::ll_src_e ll_src,
   output logic             tmr_irq_pulse,
   output logic             mf_sync_pulse,
   output logic             lastlook_pulse
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tmr_irq_pulse  <= 1'b0;
         mf_sync_pulse  <= 1'b0;
         lastlook_pulse <= 1'b0;
      end else begin
         tmr_irq_pulse  <= expire;
         mf_sync_pulse  <= expire & mf_mode_sel;
         lastlook_pulse <= (ll_src == pit_pkg::LL_FRAME) ? frame_ev : expire;
      end
   end

   p_mf_with_irq_r7: assert property (@(posedge clk) disable iff (!rst_n)
      mf_sync_pulse |-> tmr_irq_pulse);
   p_quiet_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(active) |-> !(tmr_irq_pulse || mf_sync_pulse || lastlook_pulse));
   p_irq_single_r11: assert property (@(posedge clk) disable iff (!rst_n)
      tmr_irq_pulse |=> !tmr_irq_pulse);
endmodule

// File: rtl/pcm_interval_timer.sv
module pcm_interval_timer #(
   parameter int TVAL_W    = 7,
   parameter int FRAME_DIV = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              frame_tick,
   input  logic              cfg_wr,
   input  logic [TVAL_W:0]   cfg_wdata,
   input  logic              start_cmd,
   input  logic              op_mode_en,
   input  logic              mf_mode_sel,
   output logic              running,
   output logic              tmr_irq_pulse,
   output logic              mf_sync_pulse,
   output logic              lastlook_pulse
);
   logic [TVAL_W-1:0] period_val;
   pit_pkg::ll_src_e  ll_src;
   logic              load, active, frame_ev, base_tick, expire;

   pit_ctrl #(.TVAL_W(TVAL_W)) u_ctrl (
      .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
      .start_cmd(start_cmd), .op_mode_en(op_mode_en), .frame_tick(frame_tick),
      .period_val(period_val), .ll_src(ll_src), .running(running),
      .load(load), .active(active), .frame_ev(frame_ev)
   );

   pit_base_div #(.FRAME_DIV(FRAME_DIV)) u_div (
      .clk(clk), .rst_n(rst_n), .restart(load), .frame_ev(frame_ev),
      .base_tick(base_tick)
   );

   pit_period_cnt #(.TVAL_W(TVAL_W)) u_cnt (
      .clk(clk), .rst_n(rst_n), .load(load), .reload_val(period_val),
      .base_tick(base_tick), .running(running), .expire(expire)
   );

   pit_strobe_out u_out (
      .clk(clk), .rst_n(rst_n), .expire(expire), .frame_ev(frame_ev),
      .active(active), .mf_mode_sel(mf_mode_sel), .ll_src(ll_src),
      .tmr_irq_pulse(tmr_irq_pulse), .mf_sync_pulse(mf_sync_pulse),
      .lastlook_pulse(lastlook_pulse)
   );

   p_stopped_no_irq_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (!running && !start_cmd) |=> !tmr_irq_pulse);
endmodule

// File: tb/pcm_interval_timer_tb.sv
module pcm_interval_timer_tb;
   localparam int CLK_PERIOD = 10;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       frame_tick = 1'b0;
   logic       cfg_wr = 1'b0;
   logic [7:0] cfg_wdata = 8'h00;
   logic       start_cmd = 1'b0;
   logic       op_mode_en = 1'b1;
   logic       mf_mode_sel = 1'b0;
   logic       running, tmr_irq_pulse, mf_sync_pulse, lastlook_pulse;

   int checks = 0;
   int errors = 0;
   int n_irq, n_mf, n_ll, first_irq, idle_hits;

   always #(CLK_PERIOD/2) clk = ~clk;

   pcm_interval_timer u_dut (
      .clk(clk), .rst_n(rst_n), .frame_tick(frame_tick), .cfg_wr(cfg_wr),
      .cfg_wdata(cfg_wdata), .start_cmd(start_cmd), .op_mode_en(op_mode_en),
      .mf_mode_sel(mf_mode_sel), .running(running), .tmr_irq_pulse(tmr_irq_pulse),
      .mf_sync_pulse(mf_sync_pulse), .lastlook_pulse(lastlook_pulse)
   );

   task automatic check(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic wr_cfg(input logic [7:0] v, input logic with_start);
      @(negedge clk);
      cfg_wr = 1'b1; cfg_wdata = v; start_cmd = with_start;
      @(negedge clk);
      cfg_wr = 1'b0; start_cmd = 1'b0;
   endtask

   task automatic start();
      @(negedge clk);
      start_cmd = 1'b1;
      @(negedge clk);
      start_cmd = 1'b0;
   endtask

   // drive n frame ticks, 4 cycles apart; count pulses and first irq tick index
   task automatic measure(input int n);
      n_irq = 0; n_mf = 0; n_ll = 0; first_irq = 0; idle_hits = 0;
      for (int i = 1; i <= n; i++) begin
         @(negedge clk);
         frame_tick = 1'b1;
         @(negedge clk);
         frame_tick = 1'b0;
         if (tmr_irq_pulse) begin
            n_irq++;
            if (first_irq == 0) first_irq = i;
         end
         if (mf_sync_pulse)  n_mf++;
         if (lastlook_pulse) n_ll++;
         for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            if (tmr_irq_pulse || mf_sync_pulse || lastlook_pulse) idle_hits++;
         end
      end
   endtask

   task automatic t_reset();
      check("R1 running", running, 0);
      check("R1 irq", tmr_irq_pulse, 0);
      check("R1 mf", mf_sync_pulse, 0);
      check("R1 lastlook", lastlook_pulse, 0);
      start();
      measure(6);
      check("R1 default period count", n_irq, 3);
      check("R1 default first fire", first_irq, 2);
      check("R11 no pulse off tick", idle_hits, 0);
   endtask

   task automatic t_period_mf();
      mf_mode_sel = 1'b1;
      wr_cfg(8'h03, 1'b0);
      start();
      check("R3 running", running, 1);
      measure(24);
      check("R2 irq count", n_irq, 3);
      check("R2 first fire", first_irq, 8);
      check("R7 mf count", n_mf, 3);
      check("R8 lastlook count", n_ll, 3);
      check("R11 width", idle_hits, 0);
      mf_mode_sel = 1'b0;
      measure(8);
      check("R7 mf off", n_mf, 0);
      check("R2 periodic irq", n_irq, 1);
      check("R2 periodic position", first_irq, 8);
   endtask

   task automatic t_write_stop();
      wr_cfg(8'h85, 1'b0);
      check("R4 write stops", running, 0);
      measure(20);
      check("R6 quiet irq", n_irq, 0);
      check("R6 quiet lastlook", n_ll, 0);
      start();
      measure(24);
      check("R10 new period count", n_irq, 2);
      check("R10 new period first", first_irq, 12);
      check("R9 lastlook every tick", n_ll, 24);
   endtask

   task automatic t_write_start_same();
      wr_cfg(8'h00, 1'b1);
      check("R4 write beats start", running, 0);
      measure(10);
      check("R6 no irq after collision", n_irq, 0);
   endtask

   task automatic t_mode();
      start();
      check("R3 started", running, 1);
      @(negedge clk);
      op_mode_en = 1'b0;
      @(negedge clk);
      check("R5 mode stop", running, 0);
      start();
      check("R3 start ignored when mode low", running, 0);
      measure(6);
      check("R6 quiet with mode low", n_irq + n_ll, 0);
      op_mode_en = 1'b1;
   endtask

   task automatic t_max();
      wr_cfg(8'h7F, 1'b0);
      start();
      measure(256);
      check("R2 max period count", n_irq, 1);
      check("R2 max period first", first_irq, 256);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_period_mf();
      t_write_stop();
      t_write_start_same();
      t_mode();
      t_max();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 150000);
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule